// File: doc/BRIEF.md
# Multi-mode ADC serial output controller

This block is the serial output side of a 16-bit sampling converter. It times each conversion from a master clock and makes one result bit every four master clocks. It presents the result MSB first on a single data line, in one of four modes chosen by two strap inputs. When the clock-mode strap is low, the block drives its own bit clock at a quarter of the master clock. Each bit then appears as soon as it is decided. When the clock-mode strap is high, the bit clock comes from the outside and is resynchronised to the master clock. A finished word then waits in a shift register until that external clock reads it out.

With both straps high the block runs pipelined. A falling edge of the hold strobe starts conversion N+1 and, at the same moment, loads the result of conversion N for readout. A word that is only partly read when the next hold edge arrives is dropped. The other modes are:
- clock strap high, output strap low: the word is loaded as soon as its conversion ends.
- clock strap low, output strap high: self-clocked, and each conversion waits for a hold edge.
- both straps low: self-clocked, and a new conversion starts by itself after each one ends.

A behavioural stand-in replaces the converter core. It captures the 16-bit input value when a conversion starts and reveals it one bit per four-clock slot.

Top module: `adc_serial_out`

## Requirements
- R1: `sclk_oe` is 1 (the block drives the bit clock) exactly when `sck_mode` is 0, and 0 when `sck_mode` is 1.
- R2: Self-clocked (`sck_mode`=0): during a conversion `sclk_out` is low for two master clocks and then high for two, once per bit slot. Slot k carries bit 15-k of the captured value on `sdata`, so the MSB comes first. Each new bit appears together with a falling edge of `sclk_out`.
- R3: Self-clocked, no conversion in progress: `sdata` and `sclk_out` are both 1.
- R4: In every mode except free-run, a conversion starts on the first master clock edge after `hold_n` falls. A `hold_n` falling edge while `busy` is 1 is ignored. `busy` stays high for exactly 64 master clocks per conversion.
- R5: Free-run (`sck_mode`=0, `out_mode`=0): a conversion starts on the first master clock after reset without any hold edge. Each following conversion starts after one idle clock with `busy` low. Each conversion captures `sample_in` afresh.
- R6: Pipelined (both straps 1): at a hold falling edge, the result of the most recent completed conversion is loaded and its MSB appears on `sdata`. Before any conversion has completed, the load gives all ones and `sdata` stays 1.
- R7: External-clock modes (`sck_mode`=1): each falling edge of `sclk_in` moves `sdata` on to the next lower bit. The new bit is in place within three master clocks of the edge.
- R8: External-clock modes: once bit 0 has been shifted past, every further `sclk_in` falling edge leaves `sdata` at 1.
- R9: Pipelined: bits not yet read when the next hold falling edge arrives are discarded. The newly completed result replaces them, starting from its MSB.
- R10: `word_ch` gives the `ch_sel` value sampled at the start of the conversion whose result is currently loaded for external readout.
- R11: Clock strap high, output strap low: `sdata` stays 1 while a conversion runs. The result is loaded, MSB first on `sdata`, on the clock edge that ends the conversion, with no hold edge needed.
- R12: A synchronous active-high `rst` ends any conversion, drops any pending word, and leaves `sdata`=1, `sclk_out`=1 and `busy`=0.
- R13: In the self-clocked modes, activity on `sclk_in` has no effect on `sdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| hold_n | input | 1 | Hold strobe; a falling edge starts a conversion |
| ch_sel | input | 1 | Channel select, sampled when a conversion starts |
| sck_mode | input | 1 | Clock strap: 1 selects an external bit clock |
| out_mode | input | 1 | Output strap: selects between the two modes of each clock setting |
| sample_in | input | 16 | Value the stand-in core decides bit by bit |
| sclk_in | input | 1 | External bit clock |
| sclk_out | output | 1 | Bit clock driven by the block in self-clocked modes |
| sclk_oe | output | 1 | High when `sclk_out` should drive the clock pin |
| sdata | output | 1 | Serial data, MSB first |
| word_ch | output | 1 | Channel of the word held for external readout |
| busy | output | 1 | A conversion is in progress |

## Verification
The self-clocked path is tried with an alternating-nibble value while `sclk_in` toggles on its own. This separates correct slot timing from any leakage of the external clock. The pipelined path is run three ways:
- a first conversion with nothing yet to read, which must give ones;
- a full read followed by surplus clock edges, which must give ones;
- a read cut short by a new hold edge, which must give the new word from its MSB.
The ones-padding case is told apart from a word that ends in ones by choosing results whose low bits differ. Free-run is told apart from hold-triggered operation by the single idle cycle between conversions and by a changed input value showing up in the next word. The post-conversion mode is told apart from pipelined mode because its word appears without any hold edge.

// File: rtl/adc_serial_out.sv
module adc_serial_out #(
  parameter int W   = 16,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         hold_n,
  input  logic         ch_sel,
  input  logic         sck_mode,
  input  logic         out_mode,
  input  logic [W-1:0] sample_in,
  input  logic         sclk_in,
  output logic         sclk_out,
  output logic         sclk_oe,
  output logic         sdata,
  output logic         word_ch,
  output logic         busy
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  logic          hold_q;
  logic [2:0]    sync;
  logic [PW-1:0] phase;
  logic [CW-1:0] bit_n;
  logic [W-1:0]  samp, res_word, shreg, cur_word;
  logic          conv_ch, res_ch, res_valid;

  wire free_run  = !sck_mode && !out_mode;
  wire pipe      = sck_mode && out_mode;
  wire post      = sck_mode && !out_mode;
  wire hold_fall = hold_q && !hold_n;
  wire start     = !busy && (free_run || hold_fall);
  wire slot_end  = busy && (phase == PW'(DIV-1));
  wire last      = slot_end && (bit_n == CW'(W-1));
  wire sh_fall   = sync[2] && !sync[1];
  wire load_pipe = pipe && start;
  wire load_post = post && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q    <= 1'b1;
      sync      <= '1;
      busy      <= 1'b0;
      phase     <= '0;
      bit_n     <= '0;
      samp      <= '0;
      conv_ch   <= 1'b0;
      res_word  <= '0;
      res_ch    <= 1'b0;
      res_valid <= 1'b0;
    end else begin
      hold_q <= hold_n;
      sync   <= {sync[1:0], sclk_in};
      if (start) begin
        busy    <= 1'b1;
        phase   <= '0;
        bit_n   <= '0;
        samp    <= sample_in;
        conv_ch <= ch_sel;
      end else if (busy) begin
        phase <= phase + 1'b1;
        if (slot_end) bit_n <= bit_n + 1'b1;
        if (last) begin
          busy      <= 1'b0;
          res_word  <= samp;
          res_ch    <= conv_ch;
          res_valid <= 1'b1;
        end
      end
      if (load_pipe) res_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shreg   <= '1;
      word_ch <= 1'b0;
    end else if (load_pipe) begin
      shreg   <= res_valid ? res_word : '1;
      word_ch <= res_ch;
    end else if (load_post) begin
      shreg   <= samp;
      word_ch <= conv_ch;
    end else if (sck_mode && sh_fall) begin
      shreg <= {shreg[W-2:0], 1'b1};
    end
  end

  assign cur_word = samp << bit_n;
  assign sclk_oe  = !sck_mode;
  assign sclk_out = (!sck_mode && busy) ? phase[PW-1] : 1'b1;
  assign sdata    = sck_mode ? shreg[W-1] : (busy ? cur_word[W-1] : 1'b1);
endmodule

module adc_serial_out_chk #(
  parameter int W   = 16,
  parameter int DIV = 4
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           sck_mode,
  input logic                           busy,
  input logic                           sdata,
  input logic                           sclk_out,
  input logic [W-1:0]                   shreg,
  input logic [((W > 1) ? $clog2(W) : 1)-1:0] bit_n,
  input logic                           load_pipe,
  input logic                           load_post
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  p_idle_lines_r3: assert property (@(posedge clk) disable iff (rst)
    (!sck_mode && !busy) |-> (sdata && sclk_out));

  p_sclk_width_r2: assert property (@(posedge clk) disable iff (rst)
    (!sck_mode && busy && $rose(sclk_out)) |=> sclk_out);

  p_bit_on_fall_r2: assert property (@(posedge clk) disable iff (rst)
    (!sck_mode && $stable(sck_mode) && busy && $past(busy) && (sdata != $past(sdata)))
      |-> $fell(sclk_out));

  p_ones_after_r8: assert property (@(posedge clk) disable iff (rst)
    (sck_mode && $stable(sck_mode) && $past(shreg == '1) && !$past(load_pipe || load_post))
      |-> sdata);

  p_conv_len_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ($past(bit_n) == CW'(W-1)));
endmodule

bind adc_serial_out adc_serial_out_chk #(.W(W), .DIV(DIV)) u_chk (
  .clk(clk), .rst(rst), .sck_mode(sck_mode), .busy(busy), .sdata(sdata),
  .sclk_out(sclk_out), .shreg(shreg), .bit_n(bit_n),
  .load_pipe(load_pipe), .load_post(load_post)
);

// File: tb/adc_serial_out_test.sv
module adc_serial_out_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  logic clk = 1'b0, rst = 1'b1, hold_n = 1'b1, ch_sel = 1'b0;
  logic sck_mode = 1'b0, out_mode = 1'b1, sclk_in = 1'b1;
  logic [W-1:0] sample_in = '0;
  logic sclk_out, sclk_oe, sdata, word_ch, busy;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic  exp_q[$];
  string req_q[$];

  adc_serial_out #(.W(W), .DIV(4)) uut (
    .clk(clk), .rst(rst), .hold_n(hold_n), .ch_sel(ch_sel),
    .sck_mode(sck_mode), .out_mode(out_mode), .sample_in(sample_in),
    .sclk_in(sclk_in), .sclk_out(sclk_out), .sclk_oe(sclk_oe),
    .sdata(sdata), .word_ch(word_ch), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(logic sck, logic outm);
    @(negedge clk);
    sck_mode = sck; out_mode = outm; rst = 1'b1;
    cyc(3);
    rst = 1'b0;
  endtask

  task automatic hold_pulse(logic ch, logic [W-1:0] val);
    sample_in = val; ch_sel = ch; hold_n = 1'b0;
    cyc(1);
    hold_n = 1'b1;
  endtask

  task automatic sclk_pulse();
    sclk_in = 1'b0; cyc(4);
    sclk_in = 1'b1; cyc(4);
  endtask

  task automatic push_word(logic [W-1:0] w, int nbits, int extra, string req);
    for (int i = 0; i < nbits; i++) begin
      exp_q.push_back(w[W-1-i]); req_q.push_back(req);
    end
    for (int i = 0; i < extra; i++) begin
      exp_q.push_back(1'b1); req_q.push_back("R8");
    end
  endtask

  task automatic pop_check();
    logic e; string r;
    if (exp_q.size() == 0) begin
      chk("scoreboard", 32'd0, 32'd1);
    end else begin
      e = exp_q.pop_front(); r = req_q.pop_front();
      chk(r, sdata, e);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // self-clocked, hold-triggered
    do_reset(1'b0, 1'b1);
    cyc(1);
    chk("R12 sdata", sdata, 1); chk("R12 sclk", sclk_out, 1); chk("R12 busy", busy, 0);
    chk("R1 oe", sclk_oe, 1);
    hold_pulse(1'b0, 16'hA5C3);
    push_word(16'hA5C3, W, 0, "R2/R13");
    for (int k = 0; k < W; k++) begin
      for (int j = 0; j < 4; j++) begin
        sclk_in = j[0];
        if (j == 0) begin pop_check(); chk("R2 sclk low", sclk_out, 0); end
        if (j == 2) chk("R2 sclk high", sclk_out, 1);
        cyc(1);
      end
    end
    sclk_in = 1'b1;
    chk("R3 sdata idle", sdata, 1); chk("R3 sclk idle", sclk_out, 1); chk("R4 busy end", busy, 0);

    // hold edge during a conversion is ignored
    hold_pulse(1'b0, 16'h0000);
    cyc(9);
    hold_pulse(1'b1, 16'hFFFF);
    cyc(53);
    chk("R4 still busy", busy, 1);
    cyc(1);
    chk("R4 busy dropped", busy, 0);

    // free-run
    sample_in = 16'h1234;
    do_reset(1'b0, 1'b0);
    cyc(1);
    chk("R5 auto start", busy, 1); chk("R5 msb", sdata, 0);
    sample_in = 16'hF000;
    cyc(63);
    chk("R5 busy last", busy, 1);
    cyc(1);
    chk("R5 idle gap", busy, 0);
    cyc(1);
    chk("R5 restart", busy, 1); chk("R5 new sample", sdata, 1);

    // pipelined
    do_reset(1'b1, 1'b1);
    chk("R1 oe ext", sclk_oe, 0);
    hold_pulse(1'b0, 16'h3C5A);
    chk("R6 nothing yet", sdata, 1);
    cyc(70);
    hold_pulse(1'b1, 16'hC3A4);
    chk("R10 ch", word_ch, 0);
    push_word(16'h3C5A, W, 2, "R7");
    pop_check();
    for (int i = 0; i < W + 1; i++) begin sclk_pulse(); pop_check(); end
    hold_pulse(1'b0, 16'h0FF0);
    chk("R10 ch2", word_ch, 1);
    push_word(16'hC3A4, 3, 0, "R6");
    pop_check(); sclk_pulse(); pop_check(); sclk_pulse(); pop_check();
    cyc(70);
    hold_pulse(1'b1, 16'h5555);
    chk("R10 ch3", word_ch, 0);
    push_word(16'h0FF0, W, 1, "R9");
    pop_check();
    for (int i = 0; i < W; i++) begin sclk_pulse(); pop_check(); end

    // post-conversion external clock
    do_reset(1'b1, 1'b0);
    hold_pulse(1'b1, 16'h9A1B);
    cyc(10);
    chk("R11 quiet", sdata, 1);
    cyc(54);
    chk("R10 post ch", word_ch, 1);
    push_word(16'h9A1B, W, 1, "R11");
    pop_check();
    for (int i = 0; i < W; i++) begin sclk_pulse(); pop_check(); end

    // reset drops a pending word
    hold_pulse(1'b0, 16'h0001);
    cyc(66);
    chk("R11 msb", sdata, 0);
    do_reset(1'b1, 1'b0);
    chk("R12 dropped", sdata, 1);
    sclk_pulse();
    chk("R12 after edge", sdata, 1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule